// File: doc/BRIEF.md
# Clock Prescaler and Dual Timer Unit

This block takes a base tick stream and derives two slower tick streams from it. The base tick comes either from an on-chip oscillator enable or from the rising edges of a bidirectional clock pin. The first derived stream is a logic-array tick with eight power-of-two divide ratios. The second is a slower timer tick with its own eight ratios. Two timers count that timer tick. Each timer has its own terminal count and its own start input.

Every derived clock is a single-cycle enable pulse on one system clock. The clock pin is modelled as a data output, an output enable and an input. When the internal source is chosen, the pin carries a square wave at the logic-tick rate, using open-drain signalling: the enable is asserted only while the pin is pulled low. When the external source is chosen, the driver is released and the pin's edges become the base tick. This lets several units share one clock, with one unit acting as master and the others as slaves.

Top module: `tick_prescale_tmr`

## Requirements
- R1: `logic_tick_o` pulses once every 2^c base ticks, where c is `logic_div_i` (code 0 divides by 1, code 7 by 128).
- R2: `tmr_tick_o` pulses once every 2^(c+2) base ticks, where c is `tmr_div_i` (code 0 divides by 4, code 7 by 512). Two timer pulses are never adjacent.
- R3: With `ext_sel_i`=1, every rising edge of `pin_i` counts as one base tick after a two-flop synchroniser. `osc_tick_i` is ignored, and `pin_oe_o` stays 0.
- R4: With `ext_sel_i`=0, `pin_o` is 0 and `pin_oe_o` pulls the pin low once per logic-tick period. For divide by 1, `pin_oe_o` is a one-cycle pulse per base tick. Otherwise the pin is pulled low for the second half of the period (ratio/2 base ticks), and is released in the same cycle that `logic_tick_o` fires.
- R5: A change to `logic_div_i` or `tmr_div_i` clears that prescaler. The first pulse after the change comes after exactly the new ratio of base ticks.
- R6: A `start_i[i]` pulse clears timer i and arms it. With terminal count E taken from `end_cnt_i[i*CNT_W +: CNT_W]`, `done_o[i]` pulses one cycle after the (E+1)-th timer tick following the start, so E=0 finishes on the first tick. `start_i[i]` takes priority over a tick in the same cycle.
- R7: `done_o[i]` lasts one cycle. The timer then ignores further ticks until it is started again.
- R8: Both timers count the same timer tick and finish independently according to their own terminal counts.
- R9: While `rst_ni` is low, all pulse outputs and `pin_oe_o` are 0.
- R10: A change of `ext_sel_i` clears both prescalers, so no pulse merges base ticks counted from the old source with ticks from the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| osc_tick_i | input | 1 | On-chip oscillator base-tick enable |
| ext_sel_i | input | 1 | 0: oscillator source, pin is output; 1: pin is source |
| pin_i | input | 1 | Clock pin input level |
| pin_o | output | 1 | Clock pin output data (always low, open drain) |
| pin_oe_o | output | 1 | Clock pin drive enable (pull low) |
| logic_div_i | input | SEL_W | Logic-tick divide code |
| tmr_div_i | input | SEL_W | Timer-tick divide code |
| logic_tick_o | output | 1 | Logic-array tick pulse |
| tmr_tick_o | output | 1 | Timer tick pulse |
| start_i | input | 2 | Per-timer start pulse |
| end_cnt_i | input | 2*CNT_W | Per-timer terminal counts, timer i at bits i*CNT_W |
| done_o | output | 2 | Per-timer completion pulse |

## Verification
The bench builds the block with its default parameters: 3-bit divide codes, a logic ratio floor of 1, a timer ratio floor of 4, and 8-bit timer counts. With these values every code of both prescalers can be reached, in both source modes, within a 512-tick window; even the 512 ratio gives one whole timer pulse. The 8-bit counts allow short terminal counts, including 0, so each finish time is measured in timer ticks. Select and source changes are made in the middle of a count to show that the prescaler counters are cleared.

// File: rtl/tpt_pkg.sv
package tpt_pkg;
  localparam int NUM_TMR = 2;
  typedef enum logic {SRC_OSC = 1'b0, SRC_PIN = 1'b1} src_e;
endpackage

// File: rtl/tpt_src_sel.sv
module tpt_src_sel
  import tpt_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_tick_i,
  input  logic ext_sel_i,
  input  logic pin_i,
  output logic base_tick_o,
  output logic src_chg_o
);
  logic [SYNC_N:0] sync_q;
  src_e src, src_q;
  logic pin_rise;

  assign src = src_e'(ext_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      src_q  <= SRC_OSC;
    end else begin
      sync_q <= {sync_q[SYNC_N-1:0], pin_i};
      src_q  <= src;
    end
  end

  // sync_q[SYNC_N-1] is the last synchroniser stage, sync_q[SYNC_N] its delayed copy
  assign pin_rise    = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];
  assign base_tick_o = (src == SRC_PIN) ? pin_rise : osc_tick_i;
  assign src_chg_o   = (src != src_q);
endmodule

// File: rtl/tpt_pow2_div.sv
module tpt_pow2_div #(
  parameter int SEL_W     = 3,
  parameter int MIN_SHIFT = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             base_tick_i,
  input  logic             src_chg_i,
  input  logic             mute_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o,
  output logic             wave_o
);
  localparam int MAX_SH = MIN_SHIFT + (1 << SEL_W) - 1;
  localparam int CW     = (MAX_SH < 1) ? 1 : MAX_SH;
  localparam logic [CW:0] ONE = (CW+1)'(1);

  logic [SEL_W-1:0] sel_q;
  logic [CW-1:0]    cnt_q;
  logic [7:0]       sh;
  logic [CW:0]      lim;
  logic clr, adv, at_last, at_half, div1;
  logic tick_q, wave_q, wave_d;

  assign sh      = 8'(MIN_SHIFT) + 8'(sel_i);
  assign lim     = (ONE << sh) - ONE;
  assign clr     = src_chg_i | (sel_i != sel_q);
  assign adv     = base_tick_i & ~clr;
  assign at_last = (cnt_q == lim[CW-1:0]);
  assign at_half = (cnt_q == lim[CW:1]);
  assign div1    = (sh == 8'd0);

  // pin pulled low for second half of each period
  always_comb begin
    wave_d = wave_q;
    if (clr)                 wave_d = 1'b0;
    else if (div1)           wave_d = base_tick_i;
    else if (adv && at_last) wave_d = 1'b0;
    else if (adv && at_half) wave_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      cnt_q  <= '0;
      tick_q <= 1'b0;
      wave_q <= 1'b0;
    end else begin
      sel_q  <= sel_i;
      tick_q <= adv & at_last;
      wave_q <= wave_d & ~mute_i;
      if (clr)      cnt_q <= '0;
      else if (adv) cnt_q <= at_last ? '0 : cnt_q + CW'(1);
    end
  end

  assign tick_o = tick_q;
  assign wave_o = wave_q;
endmodule

// File: rtl/tpt_timer.sv
module tpt_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] end_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic armed_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else if (tick_i && armed_q) begin
        if (cnt_q == end_i) begin
          armed_q <= 1'b0;
          done_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/tick_prescale_tmr.sv
module tick_prescale_tmr
  import tpt_pkg::*;
#(
  parameter int SEL_W    = 3,
  parameter int LDIV_MIN = 0,
  parameter int TDIV_MIN = 2,
  parameter int CNT_W    = 8,
  parameter int SYNC_N   = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     osc_tick_i,
  input  logic                     ext_sel_i,
  input  logic                     pin_i,
  output logic                     pin_o,
  output logic                     pin_oe_o,
  input  logic [SEL_W-1:0]         logic_div_i,
  input  logic [SEL_W-1:0]         tmr_div_i,
  output logic                     logic_tick_o,
  output logic                     tmr_tick_o,
  input  logic [NUM_TMR-1:0]       start_i,
  input  logic [NUM_TMR*CNT_W-1:0] end_cnt_i,
  output logic [NUM_TMR-1:0]       done_o
);
  logic base_tick, src_chg, tmr_wave_unused;

  tpt_src_sel #(.SYNC_N(SYNC_N)) u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .osc_tick_i (osc_tick_i),
    .ext_sel_i  (ext_sel_i),
    .pin_i      (pin_i),
    .base_tick_o(base_tick),
    .src_chg_o  (src_chg)
  );

  tpt_pow2_div #(.SEL_W(SEL_W), .MIN_SHIFT(LDIV_MIN)) u_ldiv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .base_tick_i(base_tick),
    .src_chg_i  (src_chg),
    .mute_i     (ext_sel_i),
    .sel_i      (logic_div_i),
    .tick_o     (logic_tick_o),
    .wave_o     (pin_oe_o)
  );

  tpt_pow2_div #(.SEL_W(SEL_W), .MIN_SHIFT(TDIV_MIN)) u_tdiv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .base_tick_i(base_tick),
    .src_chg_i  (src_chg),
    .mute_i     (1'b1),
    .sel_i      (tmr_div_i),
    .tick_o     (tmr_tick_o),
    .wave_o     (tmr_wave_unused)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    tpt_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tmr_tick_o),
      .start_i(start_i[i]),
      .end_i  (end_cnt_i[i*CNT_W +: CNT_W]),
      .done_o (done_o[i])
    );
  end

  assign pin_o = 1'b0;
endmodule

// File: rtl/tick_prescale_tmr_chk.sv
module tick_prescale_tmr_chk
  import tpt_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int CNT_W = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     osc_tick_i,
  input logic                     ext_sel_i,
  input logic                     pin_i,
  input logic                     pin_o,
  input logic                     pin_oe_o,
  input logic [SEL_W-1:0]         logic_div_i,
  input logic [SEL_W-1:0]         tmr_div_i,
  input logic                     logic_tick_o,
  input logic                     tmr_tick_o,
  input logic [NUM_TMR-1:0]       start_i,
  input logic [NUM_TMR*CNT_W-1:0] end_cnt_i,
  input logic [NUM_TMR-1:0]       done_o
);
  logic unused_chk;
  assign unused_chk = ^{osc_tick_i, pin_i, pin_o, tmr_div_i, end_cnt_i};

  p_tmr_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_tick_o |=> !tmr_tick_o);

  p_ext_released_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_sel_i && $past(ext_sel_i) |-> !pin_oe_o);

  p_oe_release_on_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    logic_tick_o && !$past(ext_sel_i, 1) && !$past(ext_sel_i, 2) &&
    logic_div_i != '0 && $past(logic_div_i, 1) == logic_div_i &&
    $past(logic_div_i, 2) == logic_div_i |-> $fell(pin_oe_o));

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tchk
    p_done_on_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o[i] |-> $past(tmr_tick_o));
    p_start_no_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i[i] |=> !done_o[i]);
    p_done_one_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o[i] |=> !done_o[i]);
  end
endmodule

bind tick_prescale_tmr tick_prescale_tmr_chk #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tick_prescale_tmr_tb.sv
`timescale 1ns/1ps
module tick_prescale_tmr_tb;
  localparam int SEL_W = 3;
  localparam int CNT_W = 8;
  localparam int WIN   = 512;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic osc_tick_i = 1'b0, ext_sel_i = 1'b0, pin_i = 1'b0;
  logic pin_o, pin_oe_o, logic_tick_o, tmr_tick_o;
  logic [SEL_W-1:0] logic_div_i = '0, tmr_div_i = '0;
  logic [1:0] start_i = '0, done_o;
  logic [2*CNT_W-1:0] end_cnt_i = '0;

  tick_prescale_tmr u_dut (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int lcnt = 0, tcnt = 0, oe_rise = 0, oe_hi = 0;
  int since [2];
  int dcnt [2];
  int tq0[$], tq1[$], exp_q[$];
  logic oe_prev = 1'b0;
  event win_clr, win_end;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      finish_run();
    end
  end

  // monitor: counts outputs, pops timer expectations
  initial begin
    since[0] = 0; since[1] = 0; dcnt[0] = 0; dcnt[1] = 0;
    forever begin
      @(posedge clk_i); #5;
      if (logic_tick_o) lcnt++;
      if (tmr_tick_o) begin tcnt++; since[0]++; since[1]++; end
      if (pin_oe_o && !oe_prev) oe_rise++;
      if (pin_oe_o) oe_hi++;
      oe_prev = pin_oe_o;
      for (int i = 0; i < 2; i++) begin
        if (start_i[i]) since[i] = 0;
        if (done_o[i]) begin
          dcnt[i]++;
          if (i == 0) begin
            if (tq0.size() == 0) chk("R7 t0 unexpected done", 1, 0);
            else chk("R6 t0 ticks to done", since[0], tq0.pop_front());
          end else begin
            if (tq1.size() == 0) chk("R7 t1 unexpected done", 1, 0);
            else chk("R8 t1 ticks to done", since[1], tq1.pop_front());
          end
        end
      end
    end
  end

  initial forever begin
    @(win_clr);
    lcnt = 0; tcnt = 0; oe_rise = 0; oe_hi = 0;
  end

  initial forever begin
    @(win_end);
    chk("R1 logic ticks", lcnt, exp_q.pop_front());
    chk("R2 timer ticks", tcnt, exp_q.pop_front());
    chk("R4 oe rises", oe_rise, exp_q.pop_front());
    chk("R4 oe low cycles", oe_hi, exp_q.pop_front());
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  // oscillator tick every 4 clocks; pin toggles but must be ignored
  task automatic int_ticks(int n);
    repeat (n) begin
      osc_tick_i = 1'b1; pin_i = ~pin_i;
      @(negedge clk_i);
      osc_tick_i = 1'b0;
      idle(3);
    end
    pin_i = 1'b0;
  endtask

  // pin square wave 4 high / 4 low; oscillator pulses must be ignored
  task automatic ext_ticks(int n);
    repeat (n) begin
      pin_i = 1'b1; osc_tick_i = 1'b1;
      @(negedge clk_i);
      osc_tick_i = 1'b0;
      idle(3);
      pin_i = 1'b0; osc_tick_i = 1'b1;
      @(negedge clk_i);
      osc_tick_i = 1'b0;
      idle(3);
    end
  endtask

  task automatic window(bit ext, int k);
    ext_sel_i = ext; logic_div_i = SEL_W'(k); tmr_div_i = SEL_W'(k);
    idle(3);
    ->win_clr;
    @(negedge clk_i);
    if (ext) ext_ticks(WIN); else int_ticks(WIN);
    idle(6);
    exp_q.push_back(WIN >> k);
    exp_q.push_back(WIN >> (k + 2));
    exp_q.push_back(ext ? 0 : (WIN >> k));
    exp_q.push_back(ext ? 0 : ((k == 0) ? WIN : 2 * WIN));
    ->win_end;
    idle(2);
  endtask

  initial begin
    idle(3);
    chk("R9 logic tick in reset", int'(logic_tick_o), 0);
    chk("R9 timer tick in reset", int'(tmr_tick_o), 0);
    chk("R9 oe in reset", int'(pin_oe_o), 0);
    chk("R9 done in reset", int'(done_o), 0);
    rst_ni = 1'b1;
    idle(3);
    chk("R4 pin data low", int'(pin_o), 0);

    // R1 R2 R4: internal source, all codes
    for (int k = 0; k < 8; k++) window(1'b0, k);

    // R5: mid-count select change restarts the count
    ext_sel_i = 1'b0; logic_div_i = 3'd3; idle(3);
    ->win_clr; @(negedge clk_i);
    int_ticks(5);
    logic_div_i = 3'd2; idle(3);
    int_ticks(3); idle(3);
    chk("R5 no early pulse after change", lcnt, 0);
    int_ticks(1); idle(3);
    chk("R5 pulse after new ratio", lcnt, 1);

    // R10: source switch clears prescaler
    ->win_clr; @(negedge clk_i);
    int_ticks(3); idle(6);
    ext_sel_i = 1'b1; idle(3);
    ext_ticks(1); idle(4);
    chk("R10 no merged pulse", lcnt, 0);
    ext_ticks(3); idle(4);
    chk("R10 pulse after full ratio", lcnt, 1);

    // R3: external source, all codes
    for (int k = 0; k < 8; k++) window(1'b1, k);

    // R6 R7 R8: timers on divide-by-4 timer tick
    ext_sel_i = 1'b0; tmr_div_i = 3'd0; logic_div_i = 3'd0; idle(4);
    end_cnt_i = {8'd5, 8'd0};
    tq0.push_back(1); tq1.push_back(6);
    start_i = 2'b11; @(negedge clk_i); start_i = 2'b00;
    int_ticks(32); idle(4);
    chk("R7 t0 single done", dcnt[0], 1);
    chk("R7 t1 single done", dcnt[1], 1);

    end_cnt_i = {8'd2, 8'd3};
    tq0.push_back(4); tq1.push_back(3);
    start_i = 2'b11; @(negedge clk_i); start_i = 2'b00;
    int_ticks(8);
    // restart t1 mid-count: count cleared
    end_cnt_i = {8'd6, 8'd3};
    tq1.delete(); tq1.push_back(7);
    start_i = 2'b10; @(negedge clk_i); start_i = 2'b00;
    int_ticks(40); idle(4);
    chk("R6 t0 done after restart", dcnt[0], 2);
    chk("R6 t1 restarted single done", dcnt[1], 2);
    chk("R8 queues drained", tq0.size() + tq1.size(), 0);

    finish_run();
  end
endmodule